// File: doc/BRIEF.md
# Indexed Addressing Postbyte Decoder

This block turns a one-byte indexed-addressing postbyte into a 16-bit effective address. When the instruction sequencer pulses `start_i`, the block captures the postbyte together with the four base registers, the program counter and the two accumulators. It then works through the mode that the postbyte encodes. Modes that need offset bytes or an absolute address pull them from a byte-stream handshake. Indirect modes read a two-byte pointer through a simple request/acknowledge read port.

At the end the block either pulses `done_o` with the effective address or pulses `illegal_o` for a reserved encoding. For auto-increment and auto-decrement modes, `done_o` comes with a write-back strobe that carries the new value of the selected base register. The block does not decode opcodes and does not carry out the operation that consumes the address.

Top module: `idx_postbyte_decoder`

## Requirements
- R1: Postbyte bits 6:5 pick the base register (0..3, in the packing order of `base_i`). When bit 7 is 0, bits 4:0 are a signed offset in the range -16..+15 that is added to that register, and no stream byte is consumed.
- R2: When bit 7 is 1 and bit 4 is 0, sub-modes 0 and 1 (bits 3:0) give the base register value as the address and strobe a write-back of that value plus 1 or plus 2 on `wb_sel_o` = bits 6:5.
- R3: Sub-modes 2 and 3 subtract 1 or 2 from the base register. The result is the address and is also the written-back value.
- R4: Sub-mode 5 adds B sign-extended, sub-mode 6 adds A sign-extended, and sub-mode B adds the 16-bit value formed with A as the high byte and B as the low byte. Sub-mode 4 adds zero.
- R5: Sub-modes 8 and C take one stream byte, which is sign-extended. Sub-modes 9 and D take two stream bytes, high byte first. `nbytes_o` reports how many bytes were consumed, and the block never consumes more.
- R6: Sub-modes C and D add the offset to `pc_i` plus the number of offset bytes consumed, in place of a base register.
- R7: When bit 7 and bit 4 are both 1, the computed address is a pointer. The block reads the byte at the pointer (high) and the byte at pointer+1 (low), and that pair becomes the effective address.
- R8: Postbyte 0x9F (indirect, sub-mode F, register field 0) takes a 16-bit absolute pointer from the stream, high byte first, and dereferences it as in R7.
- R9: Sub-modes 7, A and E, sub-modes 0 and 2 with bit 4 set, sub-mode F with bit 4 clear, and sub-mode F with a non-zero register field are illegal. Such a postbyte raises `illegal_o` for exactly one cycle, in the cycle after the start. It gives no `done_o`, no write-back, no stream consumption and no memory read.
- R10: All address, pointer and write-back arithmetic wraps modulo 2^16.
- R11: `done_o` is a one-cycle pulse. A mode with no stream bytes and no indirection completes with `done_o` in the second cycle after the start edge.
- R12: All register inputs are sampled on the start edge. Later changes to them do not affect the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding; sampled only when idle |
| postbyte_i | input | 8 | Indexed-addressing postbyte |
| base_i | input | 4*ADDR_W | Four base registers, register 0 in the low bits |
| pc_i | input | ADDR_W | Program counter pointing just past the postbyte |
| acc_a_i | input | BYTE_W | Accumulator A |
| acc_b_i | input | BYTE_W | Accumulator B |
| strm_valid_i | input | 1 | Stream byte available |
| strm_data_i | input | BYTE_W | Stream byte |
| strm_ready_o | output | 1 | Block accepts a stream byte |
| mem_req_o | output | 1 | Pointer read request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Pointer read address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_data_i | input | BYTE_W | Read data |
| done_o | output | 1 | Effective address valid (one cycle) |
| ea_o | output | ADDR_W | Effective address |
| nbytes_o | output | 2 | Stream bytes consumed by this operation |
| wb_en_o | output | 1 | Base register write-back strobe |
| wb_sel_o | output | 2 | Base register to write back |
| wb_val_o | output | ADDR_W | Write-back value |
| illegal_o | output | 1 | Reserved postbyte seen (one cycle) |

## Verification
The bench builds the block with its default 16-bit addresses and 8-bit bytes. At that width, base registers of 0xFFFF and 0x0001 drive the post-increment, pre-decrement, offset and pointer-plus-one paths across the wrap boundary with only a handful of vectors. With the four-register packing, every register field value appears, including the non-zero fields that make sub-mode F illegal. Stall knobs on the stream and memory models hold the handshakes idle, so the results must stay the same under backpressure.

// File: rtl/idx_pkg.sv
package idx_pkg;

  localparam int unsigned NUM_BASE = 4;
  localparam int unsigned SEL_W    = 2;

  typedef enum logic [3:0] {
    K_OFS5, K_INC1, K_INC2, K_DEC1, K_DEC2, K_ZERO, K_ACCB, K_ACCA,
    K_OFS8, K_OFS16, K_ACCD, K_PC8, K_PC16, K_EXT, K_BAD
  } ea_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CALC, S_RDH, S_RDL, S_DONE, S_ILL
  } seq_state_e;

  typedef struct packed {
    ea_kind_e         kind;
    logic             indirect;
    logic             illegal;
    logic [1:0]       nbytes;
    logic [SEL_W-1:0] base_sel;
  } pb_dec_t;

endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
  import idx_pkg::*;
(
  input  logic [7:0] pb_i,
  output pb_dec_t    dec_o
);

  always_comb begin
    dec_o.kind     = K_BAD;
    dec_o.indirect = pb_i[7] & pb_i[4];
    dec_o.illegal  = 1'b0;
    dec_o.nbytes   = 2'd0;
    dec_o.base_sel = pb_i[6:5];
    if (!pb_i[7]) begin
      dec_o.kind     = K_OFS5;
      dec_o.indirect = 1'b0;
    end else begin
      case (pb_i[3:0])
        4'h0: begin dec_o.kind = K_INC1; dec_o.illegal = pb_i[4]; end
        4'h1: dec_o.kind = K_INC2;
        4'h2: begin dec_o.kind = K_DEC1; dec_o.illegal = pb_i[4]; end
        4'h3: dec_o.kind = K_DEC2;
        4'h4: dec_o.kind = K_ZERO;
        4'h5: dec_o.kind = K_ACCB;
        4'h6: dec_o.kind = K_ACCA;
        4'h8: begin dec_o.kind = K_OFS8;  dec_o.nbytes = 2'd1; end
        4'h9: begin dec_o.kind = K_OFS16; dec_o.nbytes = 2'd2; end
        4'hB: dec_o.kind = K_ACCD;
        4'hC: begin dec_o.kind = K_PC8;   dec_o.nbytes = 2'd1; end
        4'hD: begin dec_o.kind = K_PC16;  dec_o.nbytes = 2'd2; end
        4'hF: begin
          dec_o.kind    = K_EXT;
          dec_o.nbytes  = 2'd2;
          dec_o.illegal = !(pb_i[4] && (pb_i[6:5] == 2'd0));
        end
        default: dec_o.illegal = 1'b1; // 7, A, E
      endcase
    end
    if (dec_o.illegal) dec_o.nbytes = 2'd0;
  end

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  ea_kind_e              kind_i,
  input  logic [4:0]            ofs5_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [ADDR_W-1:0]     pc_i,
  input  logic [BYTE_W-1:0]     acc_a_i,
  input  logic [BYTE_W-1:0]     acc_b_i,
  input  logic [2*BYTE_W-1:0]   ofs_i,
  input  logic [1:0]            nbytes_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  wb_en_o,
  output logic [ADDR_W-1:0]     wb_val_o
);

  localparam int unsigned PAIR_W = 2 * BYTE_W;

  logic signed [4:0]        s5;
  logic signed [BYTE_W-1:0] sa, sb, s8;
  logic signed [PAIR_W-1:0] sd, s16;
  logic [ADDR_W-1:0]        x5, xa, xb, x8, xd, x16, pc_eff;

  assign s5  = ofs5_i;
  assign sa  = acc_a_i;
  assign sb  = acc_b_i;
  assign s8  = ofs_i[BYTE_W-1:0];
  assign sd  = {acc_a_i, acc_b_i};
  assign s16 = ofs_i;

  assign x5  = ADDR_W'(s5);
  assign xa  = ADDR_W'(sa);
  assign xb  = ADDR_W'(sb);
  assign x8  = ADDR_W'(s8);
  assign xd  = ADDR_W'(sd);
  assign x16 = ADDR_W'(s16);

  // PC relative uses the PC after the offset bytes
  assign pc_eff = pc_i + ADDR_W'(nbytes_i);

  always_comb begin
    addr_o   = base_i;
    wb_en_o  = 1'b0;
    wb_val_o = base_i;
    case (kind_i)
      K_OFS5:  addr_o = base_i + x5;
      K_INC1:  begin wb_en_o = 1'b1; wb_val_o = base_i + ADDR_W'(1); end
      K_INC2:  begin wb_en_o = 1'b1; wb_val_o = base_i + ADDR_W'(2); end
      K_DEC1:  begin addr_o = base_i - ADDR_W'(1); wb_en_o = 1'b1; wb_val_o = base_i - ADDR_W'(1); end
      K_DEC2:  begin addr_o = base_i - ADDR_W'(2); wb_en_o = 1'b1; wb_val_o = base_i - ADDR_W'(2); end
      K_ZERO:  addr_o = base_i;
      K_ACCB:  addr_o = base_i + xb;
      K_ACCA:  addr_o = base_i + xa;
      K_OFS8:  addr_o = base_i + x8;
      K_OFS16: addr_o = base_i + x16;
      K_ACCD:  addr_o = base_i + xd;
      K_PC8:   addr_o = pc_eff + x8;
      K_PC16:  addr_o = pc_eff + x16;
      K_EXT:   addr_o = ADDR_W'(ofs_i);
      default: addr_o = base_i;
    endcase
  end

endmodule

// File: rtl/idx_postbyte_decoder.sv
module idx_postbyte_decoder
  import idx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [7:0]                   postbyte_i,
  input  logic [NUM_BASE*ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]            pc_i,
  input  logic [BYTE_W-1:0]            acc_a_i,
  input  logic [BYTE_W-1:0]            acc_b_i,
  input  logic                         strm_valid_i,
  input  logic [BYTE_W-1:0]            strm_data_i,
  output logic                         strm_ready_o,
  output logic                         mem_req_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  input  logic                         mem_ack_i,
  input  logic [BYTE_W-1:0]            mem_data_i,
  output logic                         done_o,
  output logic [ADDR_W-1:0]            ea_o,
  output logic [1:0]                   nbytes_o,
  output logic                         wb_en_o,
  output logic [SEL_W-1:0]             wb_sel_o,
  output logic [ADDR_W-1:0]            wb_val_o,
  output logic                         illegal_o
);

  localparam int unsigned PAIR_W = 2 * BYTE_W;

  seq_state_e          state_q, state_d;
  pb_dec_t             dec_new, dec_q;
  logic [4:0]          ofs5_q;
  logic [ADDR_W-1:0]   base_q, pc_q, ea_q, wbv_q, calc_addr, calc_wbv, base_sel_val;
  logic [BYTE_W-1:0]   a_q, b_q, hi_q;
  logic [PAIR_W-1:0]   ofs_q;
  logic [1:0]          cnt_q;
  logic                wb_q, calc_wb;

  idx_pb_decode u_dec (
    .pb_i  (postbyte_i),
    .dec_o (dec_new)
  );

  assign base_sel_val = base_i[dec_new.base_sel*ADDR_W +: ADDR_W];

  idx_ea_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_calc (
    .kind_i   (dec_q.kind),
    .ofs5_i   (ofs5_q),
    .base_i   (base_q),
    .pc_i     (pc_q),
    .acc_a_i  (a_q),
    .acc_b_i  (b_q),
    .ofs_i    (ofs_q),
    .nbytes_i (dec_q.nbytes),
    .addr_o   (calc_addr),
    .wb_en_o  (calc_wb),
    .wb_val_o (calc_wbv)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start_i) begin
        if (dec_new.illegal)          state_d = S_ILL;
        else if (dec_new.nbytes != 0) state_d = S_FETCH;
        else                          state_d = S_CALC;
      end
      S_FETCH: if (strm_valid_i && (cnt_q + 2'd1 == dec_q.nbytes)) state_d = S_CALC;
      S_CALC:  state_d = dec_q.indirect ? S_RDH : S_DONE;
      S_RDH:   if (mem_ack_i) state_d = S_RDL;
      S_RDL:   if (mem_ack_i) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dec_q   <= '0;
      ofs5_q  <= '0;
      base_q  <= '0;
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      ea_q    <= '0;
      wbv_q   <= '0;
      wb_q    <= 1'b0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: if (start_i) begin
          dec_q  <= dec_new;
          ofs5_q <= postbyte_i[4:0];
          base_q <= base_sel_val;
          pc_q   <= pc_i;
          a_q    <= acc_a_i;
          b_q    <= acc_b_i;
          ofs_q  <= '0;
          cnt_q  <= '0;
          wb_q   <= 1'b0;
        end
        S_FETCH: if (strm_valid_i) begin
          ofs_q <= {ofs_q[BYTE_W-1:0], strm_data_i};
          cnt_q <= cnt_q + 2'd1;
        end
        S_CALC: begin
          ea_q  <= calc_addr;
          wb_q  <= calc_wb;
          wbv_q <= calc_wbv;
        end
        S_RDH: if (mem_ack_i) hi_q <= mem_data_i;
        S_RDL: if (mem_ack_i) ea_q <= ADDR_W'({hi_q, mem_data_i});
        default: ;
      endcase
    end
  end

  assign strm_ready_o = (state_q == S_FETCH);
  assign mem_req_o    = (state_q == S_RDH) || (state_q == S_RDL);
  assign mem_addr_o   = (state_q == S_RDL) ? ea_q + ADDR_W'(1) : ea_q;
  assign done_o       = (state_q == S_DONE);
  assign ea_o         = ea_q;
  assign nbytes_o     = dec_q.nbytes;
  assign wb_en_o      = done_o && wb_q;
  assign wb_sel_o     = dec_q.base_sel;
  assign wb_val_o     = wbv_q;
  assign illegal_o    = (state_q == S_ILL);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ill_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

  a_r9_ill_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> $past(start_i));

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r7_second_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && state_q == S_RDH) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  a_r2_wb_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);

  a_r5_no_overfetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strm_ready_o && strm_valid_i) |-> (cnt_q < dec_q.nbytes));

endmodule

// File: tb/tb_idx_postbyte_decoder.sv
module tb_idx_postbyte_decoder;

  localparam int NV = 31;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  postbyte_i = '0;
  logic [63:0] base_i = {16'h0001, 16'hFFFF, 16'h2080, 16'h1000};
  logic [15:0] pc_i = 16'h8000;
  logic [7:0]  acc_a_i = 8'h80;
  logic [7:0]  acc_b_i = 8'h7F;
  logic        strm_valid_i = 1'b0;
  logic [7:0]  strm_data_i = '0;
  logic        strm_ready_o;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic        done_o;
  logic [15:0] ea_o;
  logic [1:0]  nbytes_o;
  logic        wb_en_o;
  logic [1:0]  wb_sel_o;
  logic [15:0] wb_val_o;
  logic        illegal_o;

  idx_postbyte_decoder dut (.*);

  always #5 clk_i = ~clk_i;

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // stream and memory models, driven at negedge
  logic [7:0] sb0, sb1;
  int slen = 0, sidx = 0, sgap = 0, mgap = 0, beats = 0;
  logic take = 1'b0;

  initial forever begin
    @(negedge clk_i);
    if (take) sidx++;
    if (sgap > 0) begin strm_valid_i = 1'b0; sgap--; end
    else strm_valid_i = (sidx < slen);
    strm_data_i = (sidx == 0) ? sb0 : sb1;
    take = strm_valid_i && strm_ready_o;
    if (mem_req_o && mgap > 0) begin mem_ack_i = 1'b0; mgap--; end
    else mem_ack_i = mem_req_o;
    mem_data_i = mbyte(mem_addr_o);
    if (mem_req_o && mem_ack_i) beats++;
  end

  // {pb, s0, s1, ill, wb, nb, ea, wbv}
  localparam logic [59:0] VEC [NV] = '{
    {8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h1005, 16'h0000}, // R1
    {8'h30, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h2070, 16'h0000}, // R1
    {8'h5F, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'hFFFE, 16'h0000}, // R1
    {8'h6F, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0010, 16'h0000}, // R1
    {8'h80, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'h1000, 16'h1001}, // R2
    {8'hC1, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'hFFFF, 16'h0001}, // R2 R10
    {8'hE2, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'h0000, 16'h0000}, // R3
    {8'hE3, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'hFFFF, 16'hFFFF}, // R3 R10
    {8'hA4, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h2080, 16'h0000}, // R4
    {8'h85, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h107F, 16'h0000}, // R4
    {8'h86, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0F80, 16'h0000}, // R4
    {8'h8B, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h907F, 16'h0000}, // R4
    {8'h88, 8'hFE, 8'h00, 1'b0, 1'b0, 2'd1, 16'h0FFE, 16'h0000}, // R5
    {8'hA9, 8'h12, 8'h34, 1'b0, 1'b0, 2'd2, 16'h32B4, 16'h0000}, // R5
    {8'h8C, 8'h10, 8'h00, 1'b0, 1'b0, 2'd1, 16'h8011, 16'h0000}, // R6
    {8'h8D, 8'hFF, 8'h00, 1'b0, 1'b0, 2'd2, 16'h7F02, 16'h0000}, // R6
    {8'h87, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h8A, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h8E, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h90, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h92, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'hB7, 8'h00, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h8F, 8'h12, 8'h34, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'hBF, 8'h12, 8'h34, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000}, // R9
    {8'h94, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h4A4B, 16'h0000}, // R7
    {8'h91, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'h4A4B, 16'h1002}, // R7 R2
    {8'h93, 8'h00, 8'h00, 1'b0, 1'b1, 2'd0, 16'hABAA, 16'h0FFE}, // R7 R3
    {8'h9F, 8'h12, 8'h34, 1'b0, 1'b0, 2'd2, 16'h7C7D, 16'h0000}, // R8
    {8'h9C, 8'h00, 8'h00, 1'b0, 1'b0, 2'd1, 16'hDBD8, 16'h0000}, // R7 R6
    {8'hD8, 8'h01, 8'h00, 1'b0, 1'b0, 2'd1, 16'h5A5B, 16'h0000}, // R7 R10
    {8'hD4, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 16'h5A5A, 16'h0000}  // R7 R10
  };

  logic        r_done, r_ill, r_ill_next, r_late, r_wb;
  logic [15:0] r_ea, r_wbv;
  logic [1:0]  r_sel, r_nb;
  int          r_lat;
  logic        poke = 1'b0;

  task automatic run_op(input logic [7:0] pb, input logic [7:0] b0, input logic [7:0] b1);
    @(posedge clk_i); #1;
    sb0 = b0; sb1 = b1; slen = 2; sidx = 0; take = 1'b0; beats = 0;
    postbyte_i = pb; start_i = 1'b1;
    r_done = 0; r_ill = 0; r_ill_next = 0; r_late = 0; r_lat = -1;
    for (int i = 0; i < 40 && !r_done && !r_ill; i++) begin
      @(posedge clk_i); #1;
      if (i == 0) begin
        start_i = 1'b0;
        if (poke) base_i[15:0] = 16'h5555;
      end
      if (done_o) begin
        r_done = 1; r_lat = i; r_ea = ea_o; r_wb = wb_en_o;
        r_wbv = wb_val_o; r_sel = wb_sel_o; r_nb = nbytes_o;
      end else if (illegal_o) begin
        r_ill = 1; r_lat = i;
        @(posedge clk_i); #1;
        r_ill_next = illegal_o;
        for (int k = 0; k < 4; k++) begin
          r_late = r_late | done_o | wb_en_o | mem_req_o | strm_ready_o;
          @(posedge clk_i); #1;
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11", {28'd0, done_o, illegal_o, strm_ready_o, mem_req_o}, 32'd0, "reset outputs");
    chk("R2", wb_en_o, 1'b0, "reset wb");
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [59:0] e;
      logic ind;
      e = VEC[v];
      ind = e[59] & e[56];
      run_op(e[59:52], e[51:44], e[43:36]);
      if (e[35]) begin
        chk("R9", {r_ill, r_done}, 2'b10, $sformatf("pb %02h illegal flag", e[59:52]));
        chk("R9", r_lat, 0, "illegal latency");
        chk("R9", r_ill_next, 1'b0, "illegal one cycle");
        chk("R9", r_late, 1'b0, "no activity after illegal");
        chk("R9", sidx, 0, "no stream bytes");
        chk("R9", beats, 0, "no memory reads");
      end else begin
        chk("R1", r_done, 1'b1, $sformatf("pb %02h done", e[59:52]));
        chk(e[59] ? "R4" : "R1", r_ea, e[31:16], $sformatf("pb %02h ea", e[59:52]));
        chk("R5", r_nb, e[33:32], "nbytes");
        chk("R5", sidx, int'(e[33:32]), "bytes consumed");
        chk("R7", beats, ind ? 2 : 0, "read beats");
        chk("R2", r_wb, e[34], "wb strobe");
        if (e[34]) begin
          chk("R3", r_wbv, e[15:0], "wb value");
          chk("R2", r_sel, e[58:57], "wb select");
        end
      end
    end

    // R11 exact latency, no-byte direct mode
    run_op(8'h05, 8'h00, 8'h00);
    chk("R11", r_lat, 1, "done latency");

    // R12 base change after start edge
    poke = 1'b1;
    run_op(8'h84, 8'h00, 8'h00);
    poke = 1'b0;
    chk("R12", r_ea, 16'h1000, "sampled base");
    base_i[15:0] = 16'h1000;

    // R5 stream stall
    sgap = 3;
    run_op(8'hA9, 8'h12, 8'h34);
    chk("R5", r_ea, 16'h32B4, "stalled stream ea");
    chk("R5", sidx, 2, "stalled stream count");

    // R8 with memory stall
    mgap = 3;
    run_op(8'h9F, 8'h12, 8'h34);
    chk("R8", r_ea, 16'h7C7D, "stalled memory ea");
    chk("R7", beats, 2, "stalled memory beats");

    // R6 with different pc
    pc_i = 16'hFFFF;
    run_op(8'h8C, 8'h02, 8'h00);
    chk("R6", r_ea, 16'h0002, "pc wrap");
    pc_i = 16'h8000;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule